// File: doc/BRIEF.md
# Cascadable Level/Edge Interrupt Collector

This block gathers up to 32 interrupt request lines into one request output. Each line is first brought into the local clock domain. Software then sets each line to respond either to an edge or to a level, and chooses its active sense. A status word holds one pending flag per line. Edge-triggered flags stay set until software clears them by writing ones. Level-triggered flags track the line itself. An enable word decides which pending flags can raise the output.

Software reaches the configuration and the flags through a plain register bus: a byte address, a write strobe, write data and combinational read data. Writes complete on the clock edge where the strobe is high. The output is an active-high level, so several copies can form a tree. A convention reserves lines 0, 1, 30 and 31 of a main instance for the outputs of two subordinate instances. Those lines are set to level-high, and the subordinate controllers clear their own sources.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After a synchronous active-low reset the enable, type, polarity and status words read as zero, and the request output is low.
- R2: Enable bit i set to 1 lets line i's pending flag drive the request output, and a 0 masks it. Reads of the status word show the raw pending flags whether or not they are masked.
- R3: Writing the status word clears each edge-mode pending flag whose data bit is 1, and leaves flags whose data bit is 0 unchanged.
- R4: Type bit i equal to 1 makes line i edge sensitive, and 0 makes it level sensitive. An edge-mode line whose synchronised input does not change never becomes pending.
- R5: Polarity bit i equal to 1 selects a rising edge or a high level, and 0 selects a falling edge or a low level. An edge-mode line never responds to both edges.
- R6: In edge mode the pending flag is set by the selected edge and stays set until it is cleared by a write of one.
- R7: In level mode the pending flag equals the polarity-adjusted input, so writing one to its status bit has no lasting effect while the level persists.
- R8: Each input goes through two synchronising flops. A change driven before clock edge k appears in the status word after edge k+2 and at the request output after edge k+3.
- R9: The registers sit at byte addresses 0x00 (enable), 0x08 (status), 0x0C (polarity) and 0x10 (type). Any other address reads zero, and writes to it change nothing.
- R10: The request output is the registered OR, over all lines, of pending AND enable. It changes one clock after the terms that drive it.
- R11: If a selected edge and a status clear for the same line arrive on the same clock edge, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Raw asynchronous request lines |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wr_data | input | NUM_LINES | Write data |
| bus_rd_data | output | NUM_LINES | Read data for bus_addr, combinational |
| irq_out | output | 1 | Registered, active-high interrupt request |

## Verification
The hardest case to reach is an edge that arrives through the synchroniser on exactly the same clock edge as a software clear of that line. The bench schedules the input change so that the third following clock edge is the edge on which the write strobe is high. A clear that wins over the edge would then drop the flag. A second case is checking that edges of the wrong sense are ignored. For this the bench drives each edge-mode line through both transitions and reads the status word after each one. A behavioural model, built from a history queue of the sampled inputs, predicts the request output and the read data on every clock.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants for the interrupt collector: register byte offsets.
// Assumes the bus address is at least 5 bits wide.
package irq_ctrl_pkg;
    localparam int unsigned OFS_ENABLE = 32'h00;
    localparam int unsigned OFS_STATUS = 32'h08;
    localparam int unsigned OFS_POLAR  = 32'h0C;
    localparam int unsigned OFS_TYPE   = 32'h10;
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/irq_line_sync.sv
// Brings each raw request line into the clock domain through a chain of
// flops. Assumes irq_in may change at any time relative to clk.
module irq_line_sync #(
    parameter int NUM_LINES = 32,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_in,
    output logic [NUM_LINES-1:0] sync_out
);
    logic [NUM_LINES-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One synchroniser stage; stage 0 samples the raw lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= '0;
                end else if (g == 0) begin
                    chain[g] <= raw_in;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irq_line_detect.sv
// Per-line pending logic: sticky edge capture or level tracking, chosen by
// the type bit, with sense chosen by the polarity bit. Assumes inputs are
// already synchronised. A set event wins over a same-cycle clear.
module irq_line_detect #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] sync_in,
    input  logic [NUM_LINES-1:0] edge_mode,
    input  logic [NUM_LINES-1:0] high_sense,
    input  logic [NUM_LINES-1:0] clr_mask,
    output logic [NUM_LINES-1:0] pending
);
    logic [NUM_LINES-1:0] prev_in;
    logic [NUM_LINES-1:0] act_now;
    logic [NUM_LINES-1:0] act_prev;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] pend_nxt;

    // Polarity-adjusted activity now and one cycle ago, and the edge event.
    always_comb begin
        act_now  = sync_in ~^ high_sense;
        act_prev = prev_in ~^ high_sense;
        hit      = edge_mode & act_now & ~act_prev;
    end

    // Next pending value per mode: sticky with clear for edge, follow for level.
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (edge_mode[i]) begin
                pend_nxt[i] = (pending[i] & ~clr_mask[i]) | hit[i];
            end else begin
                pend_nxt[i] = act_now[i];
            end
        end
    end

    // Hold the previous synchronised sample and the pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_in <= '0;
            pending <= '0;
        end else begin
            prev_in <= sync_in;
            pending <= pend_nxt;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_chk
            // R6: an edge-mode flag not being cleared stays set.
            assert_sticky_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[g] && pending[g] && !clr_mask[g]) |=> pending[g]);
            // R4: an edge-mode line with an unchanged input stays clear.
            assert_quiet_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[g] && !pending[g] && (sync_in[g] == prev_in[g])) |=> !pending[g]);
        end
    endgenerate
endmodule

// File: rtl/irq_cfg_regs.sv
// Register file and bus decode: enable, polarity and type words, the
// status read path and the write-one-to-clear strobe. Assumes single-cycle
// writes and combinational reads.
module irq_cfg_regs
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    input  logic [NUM_LINES-1:0] pending,
    output logic [NUM_LINES-1:0] rd_data,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] type_q,
    output logic [NUM_LINES-1:0] pol_q,
    output logic [NUM_LINES-1:0] clr_mask
);
    logic hit_en, hit_st, hit_pol, hit_typ, mapped;

    // Address decode against the fixed byte offsets.
    always_comb begin
        hit_en  = (addr == ADDR_W'(OFS_ENABLE));
        hit_st  = (addr == ADDR_W'(OFS_STATUS));
        hit_pol = (addr == ADDR_W'(OFS_POLAR));
        hit_typ = (addr == ADDR_W'(OFS_TYPE));
        mapped  = hit_en | hit_st | hit_pol | hit_typ;
    end

    // Configuration word updates on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            type_q <= '0;
            pol_q  <= '0;
        end else if (wr_en) begin
            if (hit_en)  en_q   <= wr_data;
            if (hit_pol) pol_q  <= wr_data;
            if (hit_typ) type_q <= wr_data;
        end
    end

    // Clear strobe for the pending flags on a status write.
    always_comb begin
        clr_mask = (wr_en && hit_st) ? wr_data : '0;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        if (hit_en)  rd_data = en_q;
        if (hit_st)  rd_data = pending;
        if (hit_pol) rd_data = pol_q;
        if (hit_typ) rd_data = type_q;
    end

    // R9: a write to an unmapped address leaves every configuration word alone.
    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> ($stable(en_q) && $stable(type_q) && $stable(pol_q)));
endmodule

// File: rtl/irq_cascade_ctrl.sv
// Top of the interrupt collector: synchroniser, per-line detection,
// register file and the registered request output. Assumes its output
// may feed a level-high line of another instance.
module irq_cascade_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [NUM_LINES-1:0] bus_wr_data,
    output logic [NUM_LINES-1:0] bus_rd_data,
    output logic                 irq_out
);
    logic [NUM_LINES-1:0] sync_lines;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] en_q, type_q, pol_q, clr_mask;

    irq_line_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(irq_in), .sync_out(sync_lines)
    );

    irq_line_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_lines), .edge_mode(type_q),
        .high_sense(pol_q), .clr_mask(clr_mask), .pending(pend)
    );

    irq_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr_en),
        .wr_data(bus_wr_data), .pending(pend), .rd_data(bus_rd_data),
        .en_q(en_q), .type_q(type_q), .pol_q(pol_q), .clr_mask(clr_mask)
    );

    // Registered OR of the unmasked pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= |(pend & en_q);
        end
    end

    // R2: with every line masked the output is low on the next cycle.
    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_out);
endmodule

// File: tb/tb_irq_cascade_ctrl.sv
module tb_irq_cascade_ctrl;
    localparam int N  = 32;
    localparam int AW = 5;
    localparam logic [AW-1:0] A_EN = 5'h00, A_ST = 5'h08, A_POL = 5'h0C, A_TYP = 5'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr_en = 1'b0;
    logic [N-1:0]  bus_wr_data = '0;
    wire  [N-1:0]  bus_rd_data;
    wire           irq_out;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;

    irq_cascade_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_data(bus_rd_data), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    // Behavioural reference state
    logic [N-1:0] m_en, m_typ, m_pol, m_pend;
    logic         m_irq;
    logic [N-1:0] hist [$];

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_rd(input logic [AW-1:0] a);
        case (a)
            A_EN:    return m_en;
            A_ST:    return m_pend;
            A_POL:   return m_pol;
            A_TYP:   return m_typ;
            default: return '0;
        endcase
    endfunction

    // Model update on each rising edge, using the previous configuration.
    always @(posedge clk) begin
        logic [N-1:0] sn, sp, an, ap, ev, cl, nx;
        if (!rst_n) begin
            hist = '{'0, '0, '0, '0};
            m_en = '0; m_typ = '0; m_pol = '0; m_pend = '0; m_irq = 1'b0;
        end else begin
            hist.push_back(irq_in);
            if (hist.size() > 4) void'(hist.pop_front());
            sn = hist[1];
            sp = hist[0];
            an = sn ~^ m_pol;
            ap = sp ~^ m_pol;
            ev = m_typ & an & ~ap;
            cl = (bus_wr_en && bus_addr == A_ST) ? bus_wr_data : '0;
            nx = (m_typ & ((m_pend & ~cl) | ev)) | (~m_typ & an);
            m_irq  = |(m_pend & m_en);
            m_pend = nx;
            if (bus_wr_en && bus_addr == A_EN)  m_en  = bus_wr_data;
            if (bus_wr_en && bus_addr == A_POL) m_pol = bus_wr_data;
            if (bus_wr_en && bus_addr == A_TYP) m_typ = bus_wr_data;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (started && rst_n) begin
            check({{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, m_irq}, "R10 irq_out vs model");
            check(bus_rd_data, model_rd(bus_addr), "R9 read data vs model");
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        tick();
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        tick();
        bus_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [N-1:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rd_data, exp, tag);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        started = 1'b1;
        rst_n = 1'b1;
        // R1: reset values
        rd_chk(A_EN, '0, "R1 enable after reset");
        rd_chk(A_TYP, '0, "R1 type after reset");
        rd_chk(A_POL, '0, "R1 polarity after reset");
        rd_chk(A_ST, '0, "R1 status after reset");
        check({31'b0, irq_out}, '0, "R1 irq after reset");

        // R4/R5 level-low default with inputs low; R2 raw status while masked
        repeat (4) tick();
        rd_chk(A_ST, 32'hFFFF_FFFF, "R2 raw status while masked");
        check({31'b0, irq_out}, '0, "R2 masked lines keep irq low");
        irq_in = '1;
        repeat (4) tick();
        rd_chk(A_ST, '0, "R5 low level released");

        // Line 4 rising edge, line 5 falling edge, line 6 high level
        wr(A_TYP, 32'h30);
        wr(A_POL, 32'h50);
        repeat (4) tick();
        rd_chk(A_TYP, 32'h30, "R9 type readback");
        rd_chk(A_POL, 32'h50, "R9 polarity readback");
        rd_chk(A_ST, 32'h40, "R7 high level pending");
        irq_in[4] = 1'b0;
        repeat (4) tick();
        rd_chk(A_ST, 32'h40, "R5 falling edge ignored on rising line");
        irq_in[4] = 1'b1;
        repeat (4) tick();
        rd_chk(A_ST, 32'h50, "R6 rising edge sets flag");
        irq_in[4] = 1'b0;
        repeat (4) tick();
        rd_chk(A_ST, 32'h50, "R6 flag sticky after input returns");
        irq_in[5] = 1'b0;
        repeat (4) tick();
        rd_chk(A_ST, 32'h70, "R5 falling edge sets line 5");

        // R3 / R7 clearing
        wr(A_ST, 32'h10);
        rd_chk(A_ST, 32'h60, "R3 write one clears only line 4");
        wr(A_ST, 32'h40);
        repeat (2) tick();
        rd_chk(A_ST, 32'h60, "R7 level flag survives clear");

        // R10 / R2 output timing with enable
        wr(A_EN, 32'h20);
        check({31'b0, irq_out}, '0, "R10 irq one cycle after enable");
        tick();
        check({31'b0, irq_out}, 32'h1, "R10 irq raised");
        wr(A_EN, 32'h0);
        check({31'b0, irq_out}, 32'h1, "R10 irq lags mask by one cycle");
        tick();
        check({31'b0, irq_out}, '0, "R2 mask drops irq");

        // R8 latency through the synchroniser on level line 6
        wr(A_EN, 32'h40);
        repeat (2) tick();
        check({31'b0, irq_out}, 32'h1, "R8 irq from level line");
        bus_addr = A_ST;
        irq_in[6] = 1'b0;
        tick(); check({31'b0, bus_rd_data[6]}, 32'h1, "R8 status after edge k");
        tick(); check({31'b0, bus_rd_data[6]}, 32'h1, "R8 status after edge k+1");
        tick(); check({31'b0, bus_rd_data[6]}, '0, "R8 status after edge k+2");
        check({31'b0, irq_out}, 32'h1, "R8 irq after edge k+2");
        tick(); check({31'b0, irq_out}, '0, "R8 irq after edge k+3");

        // R11 edge and clear on the same clock edge
        irq_in[5] = 1'b1;
        repeat (4) tick();
        rd_chk(A_ST, 32'h20, "R6 line 5 still pending");
        irq_in[5] = 1'b0;
        tick();
        tick();
        bus_addr = A_ST; bus_wr_data = 32'h20; bus_wr_en = 1'b1;
        tick();
        bus_wr_en = 1'b0;
        rd_chk(A_ST, 32'h20, "R11 edge wins over clear");
        wr(A_ST, 32'h20);
        rd_chk(A_ST, '0, "R3 later clear takes effect");

        // R9 unmapped accesses
        wr(5'h04, 32'hFFFF_FFFF);
        rd_chk(5'h04, '0, "R9 unmapped read zero");
        rd_chk(5'h14, '0, "R9 second unmapped read zero");
        rd_chk(A_EN, 32'h40, "R9 enable unchanged by unmapped write");
        rd_chk(A_TYP, 32'h30, "R9 type unchanged by unmapped write");
        rd_chk(A_POL, 32'h50, "R9 polarity unchanged by unmapped write");

        repeat (3) tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule